// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block conditions the second operand of a 32-bit ALU before it reaches the adder or logic unit. It takes a data word, a shift kind, an amount and the current carry flag. It returns the shifted word and a shifter carry-out. The carry-out is the last bit pushed out of the word. For a rotate through carry it is the old bit 0.

The amount comes from one of two places. One is a short immediate field whose zero code has a meaning that depends on the kind. The other is the low byte of a register, which is used literally, including values of 32 and above.

The shifting logic is purely combinational. The top wraps it in one register stage so that the result, the carry-out and the resulting carry flag appear one clock after the inputs. The resulting carry flag follows the shifter carry only when the flag-update input is set.

Top module: `opsh_top`

## Requirements
- R1: With `shift_kind`=00 (logical left) and an immediate amount n in 0..31, the result is `src_val`<<n. The carry-out is bit 32−n of `src_val` for n>0, and `carry_in` for n=0. For example, 0x80000004 shifted by 1 gives 0x00000008 with carry 1, and 5 shifted by 1 gives 10.
- R2: With `shift_kind`=01 (logical right) and an immediate amount n in 1..31, the result is the zero-filled right shift and the carry-out is bit n−1. An immediate of 0 means 32: the result is 0 and the carry-out is bit 31.
- R3: With `shift_kind`=10 (arithmetic right) and an immediate amount n in 1..31, the result is the sign-filled right shift and the carry-out is bit n−1. An immediate of 0 means 32: every result bit and the carry-out equal bit 31.
- R4: With `shift_kind`=11 (rotate right) and an immediate amount n in 1..31, the result is the word rotated right by n and the carry-out is bit n−1.
- R5: With `shift_kind`=11 and an immediate of 0, the block rotates right by one through carry. The result is {`carry_in`, `src_val`[31:1]} and the carry-out is `src_val`[0].
- R6: When `amt_from_reg`=1 the amount is `reg_amt` (the 8-bit low byte of a register) and `imm_amt` is ignored. A register amount of 0 passes `src_val` through for every kind and gives a carry-out equal to `carry_in`.
- R7: For register amounts of 32 or more, logical left and logical right give a result of 0. At exactly 32 the carry-out is bit 0 (left) or bit 31 (right). Above 32 the carry-out is 0.
- R8: For register amounts of 32 or more, an arithmetic right shift fills every result bit with bit 31, and the carry-out equals bit 31.
- R9: A register rotate uses the amount modulo 32. A nonzero multiple of 32 leaves the word unchanged and gives a carry-out equal to bit 31.
- R10: `carry_flag` equals the shifter carry-out when `set_flags`=1, and equals `carry_in` when `set_flags`=0.
- R11: All outputs are registered, so they reflect the inputs of the previous clock. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_val | input | 32 | Data word to be shifted |
| shift_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_from_reg | input | 1 | 1: amount from `reg_amt`; 0: amount from `imm_amt` |
| imm_amt | input | 5 | Immediate shift amount field |
| reg_amt | input | 8 | Register shift amount (low byte) |
| carry_in | input | 1 | Current carry flag |
| set_flags | input | 1 | Flag-update request |
| shift_res | output | 32 | Registered shifted word |
| shift_cout | output | 1 | Registered shifter carry-out |
| carry_flag | output | 1 | Registered carry flag after the operation |

## Verification
On every cycle, the assertions check the following fixed relations between the amount decoder, the shifter core and the output stage:
- pass-through at a register amount of zero;
- sign fill for large arithmetic shifts;
- the all-zero result past 32 for logical left shifts;
- the rotate-through-carry bit placement;
- the unchanged word for rotates by multiples of 32;
- the carry flag hold when `set_flags` is clear;
- the one-cycle latency.

Some behaviours can only be shown by the bench's scenarios, which compare every clock against a model that shifts one bit at a time:
- the exact carry bit chosen for every amount in the middle of the range;
- the meaning of the zero immediate code for each kind;
- the reset values.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_ROR = 2'b11
  } shkind_e;
endpackage

// File: rtl/opsh_amt_sel.sv
module opsh_amt_sel
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int AMT_W  = 8
) (
  input  shkind_e            kind,
  input  logic               from_reg,
  input  logic [IMM_W-1:0]   imm_amt,
  input  logic [AMT_W-1:0]   reg_amt,
  output logic [AMT_W-1:0]   eff_amt,
  output logic               use_rrx
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  always_comb begin
    eff_amt = '0;
    use_rrx = 1'b0;
    if (from_reg) begin
      eff_amt = reg_amt;
    end else if (imm_amt == '0) begin
      unique case (kind)
        SHK_LSR, SHK_ASR: eff_amt = FULL_AMT;
        SHK_ROR:          use_rrx = 1'b1;
        default:          eff_amt = '0;
      endcase
    end else begin
      eff_amt = AMT_W'(imm_amt);
    end
  end
endmodule

// File: rtl/opsh_core.sv
module opsh_core
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] x,
  input  shkind_e           kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              rrx,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int RW = $clog2(DATA_W);

  // Returns {carry_out, result}
  function automatic logic [DATA_W:0] shift_calc(
    input logic [DATA_W-1:0] v,
    input shkind_e           k,
    input logic [AMT_W-1:0]  n,
    input logic              r_x,
    input logic              c);
    logic [DATA_W:0]          lext;
    logic [DATA_W:0]          rext;
    logic signed [DATA_W:0]   sext;
    logic [2*DATA_W-1:0]      dbl;
    logic [RW-1:0]            rn;
    int unsigned              na;
    na = 32'(n);
    rn = n[RW-1:0];
    shift_calc = {c, v};
    if (r_x) begin
      shift_calc = {v[0], c, v[DATA_W-1:1]};
    end else if (na != 0) begin
      unique case (k)
        SHK_LSL: begin
          if (na < DATA_W) begin
            lext = {1'b0, v} << n;
            shift_calc = lext;
          end else if (na == DATA_W) begin
            shift_calc = {v[0], {DATA_W{1'b0}}};
          end else begin
            shift_calc = '0;
          end
        end
        SHK_LSR: begin
          if (na < DATA_W) begin
            rext = {v, 1'b0} >> n;
            shift_calc = {rext[0], rext[DATA_W:1]};
          end else if (na == DATA_W) begin
            shift_calc = {v[DATA_W-1], {DATA_W{1'b0}}};
          end else begin
            shift_calc = '0;
          end
        end
        SHK_ASR: begin
          if (na < DATA_W) begin
            sext = {v, 1'b0};
            rext = sext >>> n;
            shift_calc = {rext[0], rext[DATA_W:1]};
          end else begin
            shift_calc = {(DATA_W+1){v[DATA_W-1]}};
          end
        end
        default: begin
          if (rn == '0) begin
            shift_calc = {v[DATA_W-1], v};
          end else begin
            dbl = {v, v} >> rn;
            shift_calc = {dbl[DATA_W-1], dbl[DATA_W-1:0]};
          end
        end
      endcase
    end
  endfunction

  always_comb begin
    {cout, res} = shift_calc(x, kind, amt, rrx, cin);
  end
endmodule

// File: rtl/opsh_top.sv
module opsh_top
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int IMM_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_val,
  input  logic [1:0]        shift_kind,
  input  logic              amt_from_reg,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [AMT_W-1:0]  reg_amt,
  input  logic              carry_in,
  input  logic              set_flags,
  output logic [DATA_W-1:0] shift_res,
  output logic              shift_cout,
  output logic              carry_flag
);
  shkind_e            kind;
  logic [AMT_W-1:0]   eff_amt;
  logic               use_rrx;
  logic [DATA_W-1:0]  core_res;
  logic               core_cout;
  logic               flag_next;

  assign kind = shkind_e'(shift_kind);

  opsh_amt_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .AMT_W(AMT_W)) amt_i (
    .kind     (kind),
    .from_reg (amt_from_reg),
    .imm_amt  (imm_amt),
    .reg_amt  (reg_amt),
    .eff_amt  (eff_amt),
    .use_rrx  (use_rrx)
  );

  opsh_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) core_i (
    .x    (src_val),
    .kind (kind),
    .amt  (eff_amt),
    .rrx  (use_rrx),
    .cin  (carry_in),
    .res  (core_res),
    .cout (core_cout)
  );

  assign flag_next = set_flags ? core_cout : carry_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_res  <= '0;
      shift_cout <= 1'b0;
      carry_flag <= 1'b0;
    end else begin
      shift_res  <= core_res;
      shift_cout <= core_cout;
      carry_flag <= flag_next;
    end
  end

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (amt_from_reg && reg_amt == '0) |-> (core_res == src_val && core_cout == carry_in)); // R6
  AST_LSL_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SHK_LSL && 32'(eff_amt) > DATA_W) |-> (core_res == '0 && !core_cout)); // R7
  AST_ASR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SHK_ASR && !use_rrx && 32'(eff_amt) >= DATA_W)
      |-> (core_res == {DATA_W{src_val[DATA_W-1]}} && core_cout == src_val[DATA_W-1])); // R8
  AST_RRX_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    use_rrx |-> (core_res[DATA_W-1] == carry_in && core_cout == src_val[0]
                 && core_res[DATA_W-2:0] == src_val[DATA_W-1:1])); // R5
  AST_ROR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (amt_from_reg && kind == SHK_ROR && reg_amt[IMM_W-1:0] == '0 && reg_amt != '0)
      |-> (core_res == src_val && core_cout == src_val[DATA_W-1])); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> (carry_flag == $past(carry_in))); // R10
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (shift_res == $past(core_res) && shift_cout == $past(core_cout))); // R11
endmodule

// File: tb/opsh_top_tb_top.sv
module opsh_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_val = '0;
  logic [1:0]  shift_kind = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [7:0]  reg_amt = '0;
  logic        carry_in = 1'b0;
  logic        set_flags = 1'b0;
  logic [31:0] shift_res;
  logic        shift_cout;
  logic        carry_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] q_res[$];
  logic        q_cout[$];
  logic        q_flag[$];
  string       q_tag[$];

  always #2ns clk = ~clk;

  opsh_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_val(src_val), .shift_kind(shift_kind),
    .amt_from_reg(amt_from_reg), .imm_amt(imm_amt), .reg_amt(reg_amt),
    .carry_in(carry_in), .set_flags(set_flags),
    .shift_res(shift_res), .shift_cout(shift_cout), .carry_flag(carry_flag)
  );

  // Behavioural model: one bit per step
  task automatic model(input logic [31:0] x, input logic [1:0] k, input logic fr,
                       input logic [4:0] im, input logic [7:0] ra, input logic c,
                       output logic [31:0] r, output logic co, output string tag);
    int n;
    bit rrx;
    rrx = 0;
    if (fr) n = ra;
    else begin
      n = im;
      if ((k == 2'd1 || k == 2'd2) && im == 0) n = 32;
      if (k == 2'd3 && im == 0) rrx = 1;
    end
    r = x; co = c;
    if (rrx) begin
      co = x[0]; r = {c, x[31:1]}; tag = "R5";
    end else begin
      for (int i = 0; i < n; i++) begin
        case (k)
          2'd0: begin co = r[31]; r = r << 1; end
          2'd1: begin co = r[0];  r = r >> 1; end
          2'd2: begin co = r[0];  r = {r[31], r[31:1]}; end
          default: begin co = r[0]; r = {r[0], r[31:1]}; end
        endcase
      end
      if (!fr) tag = (k == 0) ? "R1" : (k == 1) ? "R2" : (k == 2) ? "R3" : "R4";
      else if (n == 0 || n < 32) tag = "R6";
      else tag = (k == 2) ? "R8" : (k == 3) ? "R9" : "R7";
    end
  endtask

  task automatic compare_out();
    logic [31:0] er; logic ec, ef; string t;
    if (q_res.size() == 0) return;
    er = q_res.pop_front(); ec = q_cout.pop_front();
    ef = q_flag.pop_front(); t = q_tag.pop_front();
    n_tests++;
    if (shift_res !== er || shift_cout !== ec) begin
      n_fail++;
      $display("FAIL %s: res=%h cout=%b expected res=%h cout=%b", t, shift_res, shift_cout, er, ec);
    end
    n_tests++;
    if (carry_flag !== ef) begin
      n_fail++;
      $display("FAIL R10: carry_flag=%b expected %b", carry_flag, ef);
    end
  endtask

  task automatic step(input logic [31:0] x, input logic [1:0] k, input logic fr,
                      input logic [4:0] im, input logic [7:0] ra, input logic c,
                      input logic s);
    logic [31:0] r; logic co; string t;
    @(negedge clk);
    compare_out();
    src_val = x; shift_kind = k; amt_from_reg = fr; imm_amt = im;
    reg_amt = ra; carry_in = c; set_flags = s;
    model(x, k, fr, im, ra, c, r, co, t);
    q_res.push_back(r); q_cout.push_back(co);
    q_flag.push_back(s ? co : c); q_tag.push_back(t);
  endtask

  function automatic logic [7:0] pick_amt();
    case ($urandom_range(0, 9))
      0: return 8'd0;   1: return 8'd1;   2: return 8'd31;  3: return 8'd32;
      4: return 8'd33;  5: return 8'd64;  6: return 8'd96;  7: return 8'd255;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    #(4ns * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // Reset state, R11: outputs zero while reset is low
    src_val = 32'hFFFF_FFFF; carry_in = 1'b1; set_flags = 1'b1;
    repeat (3) @(negedge clk);
    n_tests++;
    if (shift_res !== 0 || shift_cout !== 0 || carry_flag !== 0) begin
      n_fail++;
      $display("FAIL R11: reset outputs res=%h cout=%b flag=%b expected 0 0 0",
               shift_res, shift_cout, carry_flag);
    end
    rst_n = 1'b1;
    // R1 directed
    step(32'h8000_0004, 2'd0, 0, 5'd1, 8'd0, 0, 1);
    step(32'd5,         2'd0, 0, 5'd1, 8'd0, 0, 1);
    step(32'h1234_5678, 2'd0, 0, 5'd0, 8'd0, 1, 1);
    // R2, R3 zero code means 32
    step(32'h8000_0001, 2'd1, 0, 5'd0, 8'd0, 0, 1);
    step(32'h8000_0001, 2'd2, 0, 5'd0, 8'd0, 0, 1);
    step(32'h7FFF_FFFF, 2'd2, 0, 5'd0, 8'd0, 1, 1);
    // R4 rotate and R5 rotate through carry
    step(32'h0000_0013, 2'd3, 0, 5'd4, 8'd0, 0, 1);
    step(32'h0000_0003, 2'd3, 0, 5'd0, 8'd0, 1, 1);
    step(32'h0000_0002, 2'd3, 0, 5'd0, 8'd0, 0, 1);
    // R6 register zero, imm ignored
    for (int k = 0; k < 4; k++) step(32'hDEAD_BEEF, 2'(k), 1, 5'd7, 8'd0, 1, 1);
    // R7..R9 wide register amounts
    step(32'h0000_0001, 2'd0, 1, 5'd0, 8'd32, 0, 1);
    step(32'h8000_0000, 2'd1, 1, 5'd0, 8'd32, 0, 1);
    step(32'hFFFF_FFFF, 2'd0, 1, 5'd0, 8'd33, 1, 1);
    step(32'h8000_1234, 2'd2, 1, 5'd0, 8'd200, 0, 1);
    step(32'h8000_0001, 2'd3, 1, 5'd0, 8'd64, 0, 1);
    step(32'h0000_0010, 2'd3, 1, 5'd0, 8'd36, 0, 1);
    // R10 flag hold
    step(32'h8000_0004, 2'd0, 0, 5'd1, 8'd0, 0, 0);
    // Randomised patterns
    for (int i = 0; i < 600; i++)
      step($urandom, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           5'($urandom_range(0, 31)), pick_amt(), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)));
    @(negedge clk);
    compare_out();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule